// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block is a 32-bit status and control register placed beside a SECDED checker. When the checker reports a single-bit or a multi-bit event, the register logs the upper address bits and the syndrome of that event. It also sets a sticky status bit for the kind of event seen. Capture follows a first-error-wins rule. Once either status bit is set, the log is frozen until software clears it. Clearing either status bit clears both and re-arms the capture.

The same register holds three software-controlled bits. One disables the hardware write-back of corrected reads. One enables an NMI request on a logged single-bit error. One enables a bus-error request on a logged multi-bit error. Read data is always present on the read port. A write updates the control bits, and a 1 written to a status bit clears the log.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the read value is 0x00000000, `nmiReq` and `busErrReq` are 0, and `scrubEn` is 1.
- R2: A `sbeEvt` pulse while no status is set causes the following things from the next cycle on. Bit 0 reads 1 and bit 1 reads 0. Bits 30:12 read `errAddr[31:13]`. Bits 11:4 read `errSyndrome`.
- R3: A `mbeEvt` pulse while no status is set causes the following things from the next cycle on. Bit 1 reads 1 and bit 0 reads 0. The address and syndrome fields are captured as in R2.
- R4: When `sbeEvt` and `mbeEvt` are high in the same cycle and capture is armed, the event is logged as multi-bit. Bit 1 reads 1 and bit 0 reads 0.
- R5: While bit 0 or bit 1 is set and no clear is written, new events change neither the status bits nor bits 30:4.
- R6: A write with data bit 0 or bit 1 equal to 1 clears both status bits in the next cycle. A write with both of those bits 0 leaves the status unchanged.
- R7: Write data in bits 30:4 has no effect on the read value.
- R8: Bit 31 is read/write and is loaded on every write. `scrubEn` equals the inverse of bit 31.
- R9: Bit 2 is read/write and is loaded on every write. `nmiReq` is the level of bit 0 AND bit 2.
- R10: Bit 3 is read/write and is loaded on every write. `busErrReq` is the level of bit 1 AND bit 3.
- R11: An event arriving in the same cycle as a status-clearing write is logged, even if a status bit was set before that write. The event overrides the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sbeEvt | input | 1 | Single-bit (corrected) error strobe, one cycle per event |
| mbeEvt | input | 1 | Multi-bit (uncorrectable) error strobe, one cycle per event |
| errAddr | input | 32 | Address of the access that raised the event |
| errSyndrome | input | 8 | Syndrome of the access that raised the event |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Current register value |
| nmiReq | output | 1 | NMI request level |
| busErrReq | output | 1 | System bus-error request level |
| scrubEn | output | 1 | Write-back of corrected data enabled |

## Verification
The assertions assume that `errAddr` and `errSyndrome` are valid in any cycle where an event strobe is high. They also assume that a write and an event in the same cycle are a legal pairing. The assertions never rely on the strobes being one cycle wide. The stimulus drives each event for a single cycle with a fresh address and syndrome. It places events while the log is busy, on top of a clearing write, and in the same cycle as each other, so that every capture path is reached. All inputs return low between operations except where a same-cycle case is the point of the test.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  // fixed low control/status positions; software decodes these
  localparam int BIT_SBE  = 0;
  localparam int BIT_MBE  = 1;
  localparam int BIT_NMI  = 2;
  localparam int BIT_BERR = 3;
  localparam int FIELD_LSB = 4;

  typedef struct packed {
    logic capture;       // latch address/syndrome and set a status bit
    logic captureIsMbe;  // kind of the captured event
    logic clearStatus;   // drop both status bits
    logic loadEnables;   // take the control bits from write data
  } ctlStrobes_t;

endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sbeEvt,
  input  logic        mbeEvt,
  input  logic        wrEn,
  input  logic        wrClrSbe,
  input  logic        wrClrMbe,
  input  logic        logBusy,
  output ctlStrobes_t strobes
);

  logic anyEvt;
  logic clearReq;
  logic armed;

  assign anyEvt   = sbeEvt | mbeEvt;
  assign clearReq = wrEn & (wrClrSbe | wrClrMbe);
  // a clear in this cycle re-arms capture for an event in the same cycle
  assign armed    = ~logBusy | clearReq;

  always_comb begin
    strobes              = '0;
    strobes.loadEnables  = wrEn;
    strobes.clearStatus  = clearReq;
    strobes.capture      = anyEvt & armed;
    strobes.captureIsMbe = mbeEvt;
  end

  // R5: a busy log with no clear must never request capture
  assert_no_capture_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (logBusy && !clearReq) |-> !strobes.capture);

  // R4: multi-bit wins when both strobes arrive together
  assert_mbe_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && mbeEvt) |-> strobes.captureIsMbe);

endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int ADDR_KEEP = 19,
  parameter int SYN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [ADDR_KEEP-1:0] captAddr,
  input  logic [SYN_W-1:0]     captSyn,
  input  logic                 wdScrubDis,
  input  logic                 wdBerrEn,
  input  logic                 wdNmiEn,
  output logic                 sbeStat,
  output logic                 mbeStat,
  output logic [ADDR_KEEP-1:0] addrField,
  output logic [SYN_W-1:0]     synField,
  output logic                 scrubDis,
  output logic                 berrEn,
  output logic                 nmiEn
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbeStat   <= 1'b0;
      mbeStat   <= 1'b0;
      addrField <= '0;
      synField  <= '0;
      scrubDis  <= 1'b0;
      berrEn    <= 1'b0;
      nmiEn     <= 1'b0;
    end else begin
      if (strobes.loadEnables) begin
        scrubDis <= wdScrubDis;
        berrEn   <= wdBerrEn;
        nmiEn    <= wdNmiEn;
      end
      if (strobes.clearStatus) begin
        sbeStat <= 1'b0;
        mbeStat <= 1'b0;
      end
      if (strobes.capture) begin
        sbeStat   <= ~strobes.captureIsMbe;
        mbeStat   <= strobes.captureIsMbe;
        addrField <= captAddr;
        synField  <= captSyn;
      end
    end
  end

  // R4: at most one kind of error is ever logged
  assert_one_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sbeStat, mbeStat}));

  // R5: a logged error keeps its address and syndrome until cleared
  assert_hold_fields_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((sbeStat || mbeStat) && !strobes.clearStatus) |=>
      ($stable(addrField) && $stable(synField)));

  // R6: a clear with no competing capture empties the status
  assert_clear_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearStatus && !strobes.capture) |=> (!sbeStat && !mbeStat));

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int ADDR_KEEP = 19,
  parameter  int SYN_W     = 8,
  localparam int ADDR_LSB  = FIELD_LSB + SYN_W,
  localparam int ADDR_MSB  = ADDR_LSB + ADDR_KEEP - 1,
  localparam int BIT_SCRUB = ADDR_MSB + 1,
  localparam int REG_W     = BIT_SCRUB + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sbeEvt,
  input  logic              mbeEvt,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              nmiReq,
  output logic              busErrReq,
  output logic              scrubEn
);

  ctlStrobes_t          strobes;
  logic                 sbeStat, mbeStat;
  logic [ADDR_KEEP-1:0] addrField;
  logic [SYN_W-1:0]     synField;
  logic                 scrubDis, berrEn, nmiEn;
  logic                 unusedBits;

  // read-only field positions in write data and low address bits are not used
  assign unusedBits = ^{regWrData[ADDR_MSB:FIELD_LSB], errAddr[ADDR_W-ADDR_KEEP-1:0]};

  ecc_log_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sbeEvt   (sbeEvt),
    .mbeEvt   (mbeEvt),
    .wrEn     (regWrEn),
    .wrClrSbe (regWrData[BIT_SBE]),
    .wrClrMbe (regWrData[BIT_MBE]),
    .logBusy  (sbeStat | mbeStat),
    .strobes  (strobes)
  );

  ecc_log_dp #(
    .ADDR_KEEP (ADDR_KEEP),
    .SYN_W     (SYN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .captAddr   (errAddr[ADDR_W-1 -: ADDR_KEEP]),
    .captSyn    (errSyndrome),
    .wdScrubDis (regWrData[BIT_SCRUB]),
    .wdBerrEn   (regWrData[BIT_BERR]),
    .wdNmiEn    (regWrData[BIT_NMI]),
    .sbeStat    (sbeStat),
    .mbeStat    (mbeStat),
    .addrField  (addrField),
    .synField   (synField),
    .scrubDis   (scrubDis),
    .berrEn     (berrEn),
    .nmiEn      (nmiEn)
  );

  always_comb begin
    regRdData                       = '0;
    regRdData[BIT_SBE]              = sbeStat;
    regRdData[BIT_MBE]              = mbeStat;
    regRdData[BIT_NMI]              = nmiEn;
    regRdData[BIT_BERR]             = berrEn;
    regRdData[ADDR_LSB-1:FIELD_LSB] = synField;
    regRdData[ADDR_MSB:ADDR_LSB]    = addrField;
    regRdData[BIT_SCRUB]            = scrubDis;
  end

  assign nmiReq    = sbeStat & nmiEn;
  assign busErrReq = mbeStat & berrEn;
  assign scrubEn   = ~scrubDis;

  // R3: an armed multi-bit event shows up in the status next cycle
  assert_mbe_logged_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mbeEvt && regRdData[BIT_SBE +: 2] == 2'b00) |=> regRdData[BIT_MBE]);

  // R9: the NMI request never rises without its enable and a logged SBE
  assert_nmi_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> (regRdData[BIT_SBE] && regRdData[BIT_NMI]));

  // R10: the bus-error request never rises without its enable and a logged MBE
  assert_berr_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    busErrReq |-> (regRdData[BIT_MBE] && regRdData[BIT_BERR]));

endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sbeEvt = 1'b0, mbeEvt = 1'b0;
  logic [31:0] errAddr = '0;
  logic [7:0]  errSyndrome = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        nmiReq, busErrReq, scrubEn;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  ecc_err_log dut (
    .clk(clk), .rstN(rstN), .sbeEvt(sbeEvt), .mbeEvt(mbeEvt),
    .errAddr(errAddr), .errSyndrome(errSyndrome), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .nmiReq(nmiReq),
    .busErrReq(busErrReq), .scrubEn(scrubEn)
  );

  typedef struct {
    logic [31:0] rd;
    logic        nmi;
    logic        berr;
    logic        scrub;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  // reference state, built from the requirements
  logic        mS = 0, mM = 0, mScr = 0, mBerr = 0, mNmi = 0;
  logic [18:0] mA = '0;
  logic [7:0]  mY = '0;

  task automatic step(input logic sbe, input logic mbe, input logic [31:0] addr,
                      input logic [7:0] syn, input logic we, input logic [31:0] wd,
                      input string tag);
    logic clr, armed;
    expItem_t it;
    @(negedge clk);
    sbeEvt = sbe; mbeEvt = mbe; errAddr = addr; errSyndrome = syn;
    regWrEn = we; regWrData = wd;
    clr   = we && (wd[0] || wd[1]);
    armed = !(mS || mM) || clr;
    if (we) begin mScr = wd[31]; mBerr = wd[3]; mNmi = wd[2]; end
    if (clr) begin mS = 0; mM = 0; end
    if ((sbe || mbe) && armed) begin
      mM = mbe; mS = !mbe; mA = addr[31:13]; mY = syn;
    end
    it.rd    = {mScr, mA, mY, mBerr, mNmi, mM, mS};
    it.nmi   = mS & mNmi;
    it.berr  = mM & mBerr;
    it.scrub = !mScr;
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 32'h0, 8'h0, 1'b0, 32'h0, tag);
  endtask

  // monitor: each item belongs to the edge after it was pushed
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        expItem_t e;
        e = sbq.pop_front();
        checks++;
        if (regRdData !== e.rd || nmiReq !== e.nmi || busErrReq !== e.berr ||
            scrubEn !== e.scrub) begin
          errors++;
          $display("FAIL %s: rd=%h nmi=%b berr=%b scrub=%b expected rd=%h nmi=%b berr=%b scrub=%b",
                   e.tag, regRdData, nmiReq, busErrReq, scrubEn,
                   e.rd, e.nmi, e.berr, e.scrub);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (regRdData !== 32'h0 || nmiReq !== 1'b0 || busErrReq !== 1'b0 || scrubEn !== 1'b1) begin
      errors++;
      $display("FAIL R1: rd=%h nmi=%b berr=%b scrub=%b expected rd=00000000 nmi=0 berr=0 scrub=1",
               regRdData, nmiReq, busErrReq, scrubEn);
    end
    idle("R1 idle");
    step(0, 0, 0, 0, 1, 32'h0000_000C, "R9 R10 enables load");
    step(0, 0, 0, 0, 1, 32'h7FFF_FFFC, "R7 read-only bits ignored");
    step(1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0, "R2 single-bit capture, R9 nmi");
    idle("R2 hold");
    step(0, 1, 32'h1111_2222, 8'h33, 0, 0, "R5 mbe while busy");
    step(1, 0, 32'h4444_8888, 8'h77, 0, 0, "R5 sbe while busy");
    step(0, 0, 0, 0, 1, 32'h0000_000C, "R6 zero write keeps status");
    step(0, 0, 0, 0, 1, 32'h0000_000E, "R6 clear mbe bit clears sbe");
    step(0, 1, 32'h1234_5678, 8'hC3, 0, 0, "R3 multi-bit capture, R10 bus error");
    step(1, 0, 32'hAAAA_5555, 8'h99, 1, 32'h0000_000D, "R11 event with clear");
    step(0, 0, 0, 0, 1, 32'h0000_000D, "R6 clear sbe bit");
    step(1, 1, 32'hF0F0_0F0F, 8'hE1, 0, 0, "R4 simultaneous events");
    step(0, 0, 0, 0, 1, 32'h8000_000D, "R8 scrub disable with clear");
    step(0, 0, 0, 0, 1, 32'h0000_0000, "R8 scrub re-enable, R9 nmi off");
    step(1, 0, 32'h0000_2000, 8'h01, 0, 0, "R9 sbe without nmi enable");
    step(0, 0, 0, 0, 1, 32'h0000_0004, "R9 nmi enable after capture");
    idle("final idle");
    repeat (3) @(posedge clk);
    #6;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule